// File: doc/BRIEF.md
# Sector Erase Window and Suspend Controller

This block sits behind a flash command decoder and owns the life of a sector erase. When the decoder reports a sector-erase request, the controller opens a timed collection window. Each further sector request inside the window adds one bit to an 8-bit sector mask and starts the window over. When the window runs out, protected sectors are stripped from the mask, and the rest go to an external erase engine with a one-cycle start pulse. A foreign command inside the window throws the collection away.

While an erase is running, a suspend request takes effect after a fixed latency. A resume request sends the engine on again, and the pair may repeat any number of times. While the erase is suspended, the active mask stays visible so that the surrounding logic can refuse reads and programs aimed at those sectors. If every collected sector is protected, nothing is erased: busy goes high for a short fixed time and the block then returns to idle. All times are counted in clock cycles.

Top module: `secw_ctrl`

## Requirements
- R1: During and after a synchronous reset, before any request, erase_start, act_mask, win_open, erase_locked, suspended and busy are all 0.
- R2: A se_req seen in idle opens the window (win_open=1 after that edge). If no further request arrives, erase_start is 1 for exactly one cycle after the edge WIN_CYC cycles later. act_mask then carries the launched sectors, with bit i standing for sector index i.
- R3: A se_req inside the window sets its sector's bit and restarts the full WIN_CYC count. If it lands in the very cycle the window would have expired, the restart wins and no erase starts.
- R4: An other_cmd inside the window closes it without starting an erase and discards the collected sectors. A later window holds only the sectors requested after that point.
- R5: At launch, act_mask equals the collected mask with every sector whose prot_mask bit is 1 removed.
- R6: If every collected sector is protected at expiry, there is no erase_start, act_mask and erase_locked stay 0, and busy is 1 for exactly PROT_CYC cycles before the block returns to idle.
- R7: erase_locked is 0 while the window accepts sectors. It is 1 from launch through running, suspend-pending and suspended, until the erase ends. busy is 1 while running, while a suspend is pending and during the protected-only pulse, and 0 in idle, in the window and while suspended.
- R8: A susp_req inside the window ends it at once: suspended=1 and win_open=0 after that edge, act_mask holds the unprotected collected sectors, and erase_start does not pulse.
- R9: A susp_req during a running erase sets suspended after exactly SUSP_CYC cycles, with busy held until then. An eng_done before that returns the block to idle instead.
- R10: A resume_req while suspended pulses erase_start and clears suspended, and the erase can be suspended again afterwards. A resume_req outside suspension, or a repeated susp_req while already suspended, changes nothing.
- R11: While suspended, act_mask holds the suspended sectors unchanged, and se_req and other_cmd have no effect.
- R12: An eng_done while running returns every output to 0 on the next edge. An other_cmd while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| se_req | input | 1 | One-cycle sector-erase request from the decoder |
| se_idx | input | 3 | Sector index belonging to se_req |
| other_cmd | input | 1 | One-cycle pulse for any decoded command other than erase, suspend or resume |
| susp_req | input | 1 | One-cycle suspend request |
| resume_req | input | 1 | One-cycle resume request |
| prot_mask | input | 8 | Per-sector protection, 1 = protected |
| eng_done | input | 1 | Erase engine reports completion |
| erase_start | output | 1 | One-cycle pulse telling the engine to run (launch or resume) |
| act_mask | output | 8 | Sectors being erased or suspended |
| win_open | output | 1 | Collection window open |
| erase_locked | output | 1 | 0 while sectors can be added, 1 once the erase has begun |
| suspended | output | 1 | Erase suspended |
| busy | output | 1 | Erase running, suspend pending, or protected-only pulse |

## Verification
The sensitive collision is between window expiry and a new sector request that arrive in the same cycle. The bench counts three idle cycles after a request so that the countdown reaches zero, and then issues a second request exactly on the expiry cycle. It judges the result by the absence of erase_start on that edge and by a start exactly WIN_CYC cycles later, with both sectors in the mask. A second collision, eng_done arriving while a suspend is still pending, is provoked right after a suspend request and must leave the block idle with suspended never raised.

// File: rtl/secw_pkg.sv
package secw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WIN,
    S_RUN,
    S_SPEND,
    S_SUSP,
    S_PBUSY
  } secw_state_e;
endpackage

// File: rtl/secw_timer.sv
// Loadable down-counter that parks at zero.
module secw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/secw_mask.sv
// Collects requested sectors and filters out protected ones.
module secw_mask #(
  parameter int NSECT = 8,
  localparam int IDXW = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic [IDXW-1:0]  idx,
  input  logic [NSECT-1:0] prot,
  output logic [NSECT-1:0] eff
);
  logic [NSECT-1:0] dec;
  logic [NSECT-1:0] raw;

  for (genvar g = 0; g < NSECT; g++) begin : g_dec
    assign dec[g] = (idx == IDXW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) raw <= '0;
    else     raw <= (clr ? '0 : raw) | (add ? dec : '0);
  end

  assign eff = raw & ~prot;
endmodule

// File: rtl/secw_ctrl.sv
module secw_ctrl
  import secw_pkg::*;
#(
  parameter int NSECT    = 8,
  parameter int WIN_CYC  = 20000,
  parameter int SUSP_CYC = 3750,
  parameter int PROT_CYC = 1250,
  localparam int IDXW    = $clog2(NSECT),
  localparam int WTW     = $clog2(WIN_CYC + 1),
  localparam int AUX_MAX = (SUSP_CYC > PROT_CYC) ? SUSP_CYC : PROT_CYC,
  localparam int ATW     = $clog2(AUX_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             se_req,
  input  logic [IDXW-1:0]  se_idx,
  input  logic             other_cmd,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic [NSECT-1:0] prot_mask,
  input  logic             eng_done,
  output logic             erase_start,
  output logic [NSECT-1:0] act_mask,
  output logic             win_open,
  output logic             erase_locked,
  output logic             suspended,
  output logic             busy
);
  localparam logic [WTW-1:0] WIN_LD  = WTW'(WIN_CYC - 1);
  localparam logic [ATW-1:0] SUSP_LD = ATW'(SUSP_CYC - 1);
  localparam logic [ATW-1:0] PROT_LD = ATW'(PROT_CYC - 1);

  secw_state_e st, st_n;
  logic wload, aload, wzero, azero, m_clr, m_add, start_n;
  logic [ATW-1:0]   aval;
  logic [NSECT-1:0] eff, act_n;

  secw_timer #(.W(WTW)) u_wtmr (
    .clk(clk), .rst(rst), .load(wload), .load_val(WIN_LD), .zero(wzero)
  );

  secw_timer #(.W(ATW)) u_atmr (
    .clk(clk), .rst(rst), .load(aload), .load_val(aval), .zero(azero)
  );

  secw_mask #(.NSECT(NSECT)) u_mask (
    .clk(clk), .rst(rst), .clr(m_clr), .add(m_add), .idx(se_idx),
    .prot(prot_mask), .eff(eff)
  );

  always_comb begin
    st_n    = st;
    wload   = 1'b0;
    aload   = 1'b0;
    aval    = SUSP_LD;
    m_clr   = 1'b0;
    m_add   = 1'b0;
    start_n = 1'b0;
    act_n   = act_mask;
    unique case (st)
      S_IDLE: begin
        if (se_req) begin
          st_n  = S_WIN;
          wload = 1'b1;
          m_clr = 1'b1;
          m_add = 1'b1;
        end
      end
      S_WIN: begin
        if (other_cmd) begin
          st_n = S_IDLE;
        end else if (susp_req) begin
          if (eff == '0) begin
            st_n  = S_PBUSY;
            aload = 1'b1;
            aval  = PROT_LD;
          end else begin
            st_n  = S_SUSP;
            act_n = eff;
          end
        end else if (se_req) begin
          m_add = 1'b1;
          wload = 1'b1;
        end else if (wzero) begin
          if (eff == '0) begin
            st_n  = S_PBUSY;
            aload = 1'b1;
            aval  = PROT_LD;
          end else begin
            st_n    = S_RUN;
            start_n = 1'b1;
            act_n   = eff;
          end
        end
      end
      S_RUN: begin
        if (eng_done) begin
          st_n  = S_IDLE;
          act_n = '0;
        end else if (susp_req) begin
          st_n  = S_SPEND;
          aload = 1'b1;
          aval  = SUSP_LD;
        end
      end
      S_SPEND: begin
        if (eng_done) begin
          st_n  = S_IDLE;
          act_n = '0;
        end else if (azero) begin
          st_n = S_SUSP;
        end
      end
      S_SUSP: begin
        if (resume_req) begin
          st_n    = S_RUN;
          start_n = 1'b1;
        end
      end
      S_PBUSY: begin
        if (azero) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      erase_start  <= 1'b0;
      act_mask     <= '0;
      win_open     <= 1'b0;
      erase_locked <= 1'b0;
      suspended    <= 1'b0;
      busy         <= 1'b0;
    end else begin
      st           <= st_n;
      erase_start  <= start_n;
      act_mask     <= act_n;
      win_open     <= (st_n == S_WIN);
      erase_locked <= (st_n inside {S_RUN, S_SPEND, S_SUSP});
      suspended    <= (st_n == S_SUSP);
      busy         <= (st_n inside {S_RUN, S_SPEND, S_PBUSY});
    end
  end
endmodule

// File: rtl/secw_chk.sv
module secw_chk #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             other_cmd,
  input logic             susp_req,
  input logic             resume_req,
  input logic [NSECT-1:0] prot_mask,
  input logic             eng_done,
  input logic             erase_start,
  input logic [NSECT-1:0] act_mask,
  input logic             win_open,
  input logic             erase_locked,
  input logic             suspended,
  input logic             busy
);
  AST_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> (erase_locked && busy && !win_open)); // R2

  AST_LAUNCH_UNPROT: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_locked) |-> ((act_mask & $past(prot_mask)) == '0)); // R5

  AST_LOCK_MASK: assert property (@(posedge clk) disable iff (rst)
    erase_locked |-> (act_mask != '0)); // R6

  AST_WIN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(win_open && erase_locked) && !(busy && suspended)); // R7

  AST_FOREIGN_ABORT: assert property (@(posedge clk) disable iff (rst)
    (win_open && other_cmd) |=> (!win_open && !erase_locked && !busy)); // R4

  AST_SUSP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (win_open && susp_req && !other_cmd) |=> (!win_open && !erase_start && (suspended || busy))); // R8

  AST_RESUME_GO: assert property (@(posedge clk) disable iff (rst)
    (suspended && resume_req) |=> (erase_start && !suspended)); // R10

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (suspended && !resume_req) |=> (suspended && $stable(act_mask))); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busy && erase_locked && eng_done) |=> (!erase_locked && !busy && act_mask == '0)); // R12
endmodule

bind secw_ctrl secw_chk #(.NSECT(NSECT)) u_chk (
  .clk(clk), .rst(rst), .other_cmd(other_cmd), .susp_req(susp_req),
  .resume_req(resume_req), .prot_mask(prot_mask), .eng_done(eng_done),
  .erase_start(erase_start), .act_mask(act_mask), .win_open(win_open),
  .erase_locked(erase_locked), .suspended(suspended), .busy(busy)
);

// File: tb/secw_ctrl_bench.sv
`timescale 1ns/1ps
module secw_ctrl_bench;
  localparam int WIN  = 4;
  localparam int SUSP = 2;
  localparam int PROT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       se_req = 1'b0;
  logic [2:0] se_idx = '0;
  logic       other_cmd = 1'b0, susp_req = 1'b0, resume_req = 1'b0, eng_done = 1'b0;
  logic [7:0] prot_mask = '0;
  logic       erase_start, win_open, erase_locked, suspended, busy;
  logic [7:0] act_mask;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  secw_ctrl #(.NSECT(8), .WIN_CYC(WIN), .SUSP_CYC(SUSP), .PROT_CYC(PROT)) u_secw_ctrl (
    .clk(clk), .rst(rst), .se_req(se_req), .se_idx(se_idx), .other_cmd(other_cmd),
    .susp_req(susp_req), .resume_req(resume_req), .prot_mask(prot_mask),
    .eng_done(eng_done), .erase_start(erase_start), .act_mask(act_mask),
    .win_open(win_open), .erase_locked(erase_locked), .suspended(suspended), .busy(busy)
  );

  // inputs {se, idx[2:0], oth, sus, res, done}; outputs {start, act[7:0], win, lock, susp, busy}
  localparam logic [20:0] VEC [16] = '{
    {1'b1, 3'd1, 4'b0000, 1'b0, 8'h00, 4'b1000},  // R2 window opens
    {1'b0, 3'd0, 4'b0000, 1'b0, 8'h00, 4'b1000},
    {1'b1, 3'd2, 4'b0000, 1'b0, 8'h00, 4'b1000},  // R3 add sector 2, restart
    {1'b0, 3'd0, 4'b0000, 1'b0, 8'h00, 4'b1000},
    {1'b0, 3'd0, 4'b0000, 1'b0, 8'h00, 4'b1000},
    {1'b0, 3'd0, 4'b0000, 1'b0, 8'h00, 4'b1000},
    {1'b0, 3'd0, 4'b0000, 1'b1, 8'h02, 4'b0101},  // R5 sector 2 protected
    {1'b0, 3'd0, 4'b1000, 1'b0, 8'h02, 4'b0101},  // R12 foreign cmd ignored
    {1'b0, 3'd0, 4'b0100, 1'b0, 8'h02, 4'b0101},  // R9 suspend pending
    {1'b0, 3'd0, 4'b0000, 1'b0, 8'h02, 4'b0101},
    {1'b0, 3'd0, 4'b0000, 1'b0, 8'h02, 4'b0110},  // R9 suspended after latency
    {1'b1, 3'd5, 4'b0000, 1'b0, 8'h02, 4'b0110},  // R11 sector request ignored
    {1'b0, 3'd0, 4'b0010, 1'b1, 8'h02, 4'b0101},  // R10 resume
    {1'b0, 3'd0, 4'b0010, 1'b0, 8'h02, 4'b0101},  // R10 stray resume
    {1'b0, 3'd0, 4'b0001, 1'b0, 8'h00, 4'b0000},  // R12 done
    {1'b0, 3'd0, 4'b0000, 1'b0, 8'h00, 4'b0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
    if (erase_start) starts++;
  endtask

  task automatic clear_in();
    se_req = 1'b0; se_idx = '0; other_cmd = 1'b0;
    susp_req = 1'b0; resume_req = 1'b0; eng_done = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [12:0] exp);
    logic [12:0] got;
    got = {erase_start, act_mask, win_open, erase_locked, suspended, busy};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic sector(input logic [2:0] i);
    se_req = 1'b1; se_idx = i; tick(); clear_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    tick(); tick();
    chk("R1 outputs in reset", 13'h0000);
    rst = 1'b0;
    tick();
    chk("R1 idle after reset", 13'h0000);

    // vector table
    prot_mask = 8'h04;
    for (int i = 0; i < 16; i++) begin
      {se_req, se_idx, other_cmd, susp_req, resume_req, eng_done} = VEC[i][20:13];
      tick();
      clear_in();
      chk($sformatf("R2/R12 table row %0d", i), VEC[i][12:0]);
    end
    prot_mask = 8'h00;

    // R3: new request on the expiry cycle
    sector(3'd0);
    tick(); tick(); tick();
    sector(3'd7);
    chk("R3 retrigger wins over expiry", {1'b0, 8'h00, 4'b1000});
    tick(); tick(); tick();
    chk("R3 still open after restart", {1'b0, 8'h00, 4'b1000});
    tick();
    chk("R3 launch with both sectors", {1'b1, 8'h81, 4'b0101});
    eng_done = 1'b1; tick(); clear_in();
    chk("R12 done to idle", 13'h0000);

    // R4: foreign command aborts the window
    s0 = starts;
    sector(3'd3);
    other_cmd = 1'b1; tick(); clear_in();
    chk("R4 abort closes window", 13'h0000);
    repeat (WIN + 2) tick();
    checks++;
    if (starts != s0) begin
      errors++;
      $display("FAIL R4 no start after abort: actual=%0d expected=%0d", starts - s0, 0);
    end
    sector(3'd0);
    repeat (WIN) tick();
    chk("R4 fresh window holds only new sector", {1'b1, 8'h01, 4'b0101});
    eng_done = 1'b1; tick(); clear_in();

    // R6: everything protected
    prot_mask = 8'h40;
    sector(3'd6);
    repeat (WIN) tick();
    chk("R6 protected-only busy pulse", {1'b0, 8'h00, 4'b0001});
    tick(); tick();
    chk("R6 busy holds", {1'b0, 8'h00, 4'b0001});
    tick();
    chk("R6 back to idle", 13'h0000);
    prot_mask = 8'h00;

    // R8: suspend inside the window
    sector(3'd4);
    susp_req = 1'b1; tick(); clear_in();
    chk("R8 suspend cuts window", {1'b0, 8'h10, 4'b0110});
    susp_req = 1'b1; tick(); clear_in();
    chk("R10 redundant suspend ignored", {1'b0, 8'h10, 4'b0110});
    other_cmd = 1'b1; tick(); clear_in();
    chk("R11 foreign cmd ignored while suspended", {1'b0, 8'h10, 4'b0110});
    resume_req = 1'b1; tick(); clear_in();
    chk("R10 resume starts engine", {1'b1, 8'h10, 4'b0101});
    susp_req = 1'b1; tick(); clear_in();
    tick();
    chk("R9 pending before latency", {1'b0, 8'h10, 4'b0101});
    tick();
    chk("R10 second suspension", {1'b0, 8'h10, 4'b0110});
    resume_req = 1'b1; tick(); clear_in();
    chk("R10 second resume", {1'b1, 8'h10, 4'b0101});
    eng_done = 1'b1; tick(); clear_in();
    chk("R12 done after resumes", 13'h0000);

    // R9: done while suspend pending
    sector(3'd5);
    repeat (WIN) tick();
    chk("R2 launch sector 5", {1'b1, 8'h20, 4'b0101});
    susp_req = 1'b1; tick(); clear_in();
    eng_done = 1'b1; tick(); clear_in();
    chk("R9 done beats pending suspend", 13'h0000);
    tick(); tick();
    chk("R9 never suspended", 13'h0000);

    // R10: resume outside suspension
    resume_req = 1'b1; tick(); clear_in();
    chk("R10 resume in idle ignored", 13'h0000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule